// File: doc/BRIEF.md
# Memory-Mapped Word RAM and Panel I/O Bridge

This block sits between a small processor's 16-bit word-addressed bus and the storage and front-panel I/O it talks to. A single address decode steers each access to one of three places: a word-wide RAM in the low part of the map, two write-only LED output registers (ten red lamps, eight green lamps), and two read-only input ports (ten slide switches and the three upper push buttons). The zeroth push button is the board reset. At chip level it is inverted and fed to the active-high `rst` input, so it is never seen as data.

All storage in the block updates on the falling clock edge, while the processor runs on the rising edge. The processor presents the address, write data and strobes after its rising edge. The bridge acts on them half a cycle later and registers the read result on the same falling edge. The result is then stable and valid at the processor's next rising edge. Narrow inputs are returned zero-padded in the low bits of the 16-bit word. Accesses that match no port, or that go against a port's direction, have no effect and read as zero.

Top module: `mmio_bridge`

## Requirements
- R1: A write with `addr` in 0x0000..0x0FFF stores the 16-bit `wdata` in a RAM word indexed by that address. A later read of the same address returns that word, and each address holds its own word.
- R2: `rdata` is a register loaded at the falling edge. When `rd_en` is high at a falling edge, `rdata` shows the selected value from that edge on. When `rd_en` is low at a falling edge, `rdata` becomes 0x0000.
- R3: A write to 0x1000 loads `wdata[9:0]` into `ledr` at the falling edge, and `wdata[15:10]` is dropped. Without such a write, `ledr` holds its value.
- R4: A write to 0x1010 loads `wdata[7:0]` into `ledg` at the falling edge. Without such a write, `ledg` holds its value.
- R5: A read of 0x1040 returns `sw_in` in bits 9:0 and zeros in bits 15:10.
- R6: A read of 0x1050 returns the three button inputs in bits 2:0, with `btn_in[2]` in bit 2, and zeros in bits 15:3.
- R7: A read of 0x1000, of 0x1010, or of any address outside 0x0000..0x0FFF and the two input ports returns 0x0000.
- R8: A write to 0x1040, to 0x1050 or to an unmapped address changes neither LED register nor any RAM word, including the RAM word that the low address bits would alias to.
- R9: `rst` is sampled at the falling edge. A sampled high level clears `ledr`, `ledg` and `rdata` to zero and leaves RAM contents unchanged.
- R10: No output changes at a rising clock edge. Every output keeps the value it took at the previous falling edge.
- R11: When the same RAM address is read and written at one falling edge, `rdata` returns the word held before that write, and the new word is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the processor uses its rising edge, this block its falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled at the falling edge |
| addr | input | 16 | Word address of the current access |
| wdata | input | 16 | Data for a write access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| sw_in | input | 10 | Slide switch levels |
| btn_in | input | 3 | Push buttons three down to one |
| rdata | output | 16 | Registered read result |
| ledr | output | 10 | Red lamp register |
| ledg | output | 8 | Green lamp register |

## Verification
On every falling edge, the assertions check four things. Each LED register takes the written data one edge after a matching write and stays put otherwise. `rdata` returns to zero after an idle edge. Reads of write-only or unmapped addresses come back zero, and the button word has no bits set above the three button positions. RAM contents can only be judged across several accesses, so only the bench scenarios show the rest. These cover data surviving in the addressed word, untouched aliases after ignored writes, the read-before-write order on a shared edge, RAM surviving a reset, and outputs holding steady through the rising edge.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    localparam int BUS_W  = 16;
    localparam int SW_W   = 10;
    localparam int BTN_W  = 3;
    localparam int LEDR_W = 10;
    localparam int LEDG_W = 8;

    localparam logic [BUS_W-1:0] LEDR_ADDR = 16'h1000;
    localparam logic [BUS_W-1:0] LEDG_ADDR = 16'h1010;
    localparam logic [BUS_W-1:0] SW_ADDR   = 16'h1040;
    localparam logic [BUS_W-1:0] BTN_ADDR  = 16'h1050;

    typedef enum logic [2:0] {
        RGN_RAM,
        RGN_LEDR,
        RGN_LEDG,
        RGN_SW,
        RGN_BTN,
        RGN_NONE
    } region_e;

    typedef struct packed {
        region_e rgn;
        logic    rd;
        logic    wr;
    } access_t;

    // Map a bus address to the region that owns it.
    function automatic region_e map_addr(input logic [BUS_W-1:0] a, input int unsigned words);
        region_e r;
        if ({16'h0, a} < words)  r = RGN_RAM;
        else if (a == LEDR_ADDR) r = RGN_LEDR;
        else if (a == LEDG_ADDR) r = RGN_LEDG;
        else if (a == SW_ADDR)   r = RGN_SW;
        else if (a == BTN_ADDR)  r = RGN_BTN;
        else                     r = RGN_NONE;
        return r;
    endfunction

    // Readable regions give back data; write-only and unmapped ones read as zero.
    function automatic logic readable(input region_e r);
        return (r == RGN_RAM) || (r == RGN_SW) || (r == RGN_BTN);
    endfunction

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_pkg::*;
#(
    parameter int unsigned MEM_WORDS = 4096
) (
    input  logic [BUS_W-1:0] addr,
    input  logic             rd_en,
    input  logic             wr_en,
    output access_t          acc
);
    always_comb begin
        acc.rgn = map_addr(addr, MEM_WORDS);
        acc.rd  = rd_en;
        acc.wr  = wr_en;
    end
endmodule

// File: rtl/mmio_ram.sv
module mmio_ram
    import mmio_pkg::*;
#(
    parameter int unsigned MEM_WORDS = 4096,
    localparam int IDX_W = $clog2(MEM_WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] q
);
    logic [BUS_W-1:0] mem [MEM_WORDS];

    // Falling-edge write; the read path is combinational so the bridge's
    // output register captures the pre-write word on the same edge.
    always_ff @(negedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign q = mem[idx];
endmodule

// File: rtl/mmio_outreg.sv
module mmio_outreg
    import mmio_pkg::*;
#(
    parameter int      W     = 8,
    parameter region_e OWNER = RGN_LEDR
) (
    input  logic         clk,
    input  logic         rst,
    input  access_t      acc,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic load;
    assign load = acc.wr && (acc.rgn == OWNER);

    always_ff @(negedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    // R3 / R4: a matching write lands one falling edge later
    a_r3_r4_led_load: assert property (@(negedge clk) disable iff (rst)
        (acc.wr && acc.rgn == OWNER) |=> (q == $past(d)));

    // R3 / R4 / R8: with no matching write the register holds
    a_r8_led_hold: assert property (@(negedge clk) disable iff (rst)
        !(acc.wr && acc.rgn == OWNER) |=> $stable(q));
endmodule

// File: rtl/mmio_bridge.sv
module mmio_bridge
    import mmio_pkg::*;
#(
    parameter int unsigned MEM_WORDS = 4096,
    localparam int IDX_W = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [SW_W-1:0]   sw_in,
    input  logic [BTN_W-1:0]  btn_in,
    output logic [BUS_W-1:0]  rdata,
    output logic [LEDR_W-1:0] ledr,
    output logic [LEDG_W-1:0] ledg
);
    access_t          acc;
    logic [BUS_W-1:0] ram_q;
    logic [BUS_W-1:0] rd_sel;

    mmio_decode #(.MEM_WORDS(MEM_WORDS)) u_dec (
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .acc   (acc)
    );

    mmio_ram #(.MEM_WORDS(MEM_WORDS)) u_ram (
        .clk   (clk),
        .we    (acc.wr && acc.rgn == RGN_RAM),
        .idx   (addr[IDX_W-1:0]),
        .wdata (wdata),
        .q     (ram_q)
    );

    mmio_outreg #(.W(LEDR_W), .OWNER(RGN_LEDR)) u_red (
        .clk (clk),
        .rst (rst),
        .acc (acc),
        .d   (wdata[LEDR_W-1:0]),
        .q   (ledr)
    );

    mmio_outreg #(.W(LEDG_W), .OWNER(RGN_LEDG)) u_green (
        .clk (clk),
        .rst (rst),
        .acc (acc),
        .d   (wdata[LEDG_W-1:0]),
        .q   (ledg)
    );

    // Read selection; narrow inputs are zero-padded in the low bits.
    always_comb begin
        unique case (acc.rgn)
            RGN_RAM: rd_sel = ram_q;
            RGN_SW:  rd_sel = {{(BUS_W-SW_W){1'b0}}, sw_in};
            RGN_BTN: rd_sel = {{(BUS_W-BTN_W){1'b0}}, btn_in};
            default: rd_sel = '0;
        endcase
    end

    always_ff @(negedge clk) begin
        if (rst)         rdata <= '0;
        else if (acc.rd) rdata <= rd_sel;
        else             rdata <= '0;
    end

    // R2: an idle falling edge returns the read port to zero
    a_r2_idle_zero: assert property (@(negedge clk) disable iff (rst)
        !rd_en |=> (rdata == '0));

    // R7: write-only and unmapped addresses read as zero
    a_r7_dead_read: assert property (@(negedge clk) disable iff (rst)
        (rd_en && !readable(acc.rgn)) |=> (rdata == '0));

    // R6: the button word carries nothing above the three button bits
    a_r6_btn_pad: assert property (@(negedge clk) disable iff (rst)
        (rd_en && addr == BTN_ADDR) |=> (rdata[BUS_W-1:BTN_W] == '0));

    // R5: the switch word carries nothing above the ten switch bits
    a_r5_sw_pad: assert property (@(negedge clk) disable iff (rst)
        (rd_en && addr == SW_ADDR) |=> (rdata[BUS_W-1:SW_W] == '0));
endmodule

// File: tb/sim_mmio_bridge.sv
`timescale 1ns/1ps
module sim_mmio_bridge;
    localparam int WORDS = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  sw_in = '0;
    logic [2:0]  btn_in = '0;
    logic [15:0] rdata;
    logic [9:0]  ledr;
    logic [7:0]  ledg;

    always #2.5 clk = ~clk;

    mmio_bridge #(.MEM_WORDS(WORDS)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd_en(rd_en), .wr_en(wr_en),
        .sw_in(sw_in), .btn_in(btn_in), .rdata(rdata), .ledr(ledr), .ledg(ledg)
    );

    int unsigned n_vec  = 0;
    int unsigned n_miss = 0;
    bit          done   = 0;

    logic [15:0] model_mem [WORDS];
    logic [9:0]  e_ledr = '0;
    logic [7:0]  e_ledg = '0;
    logic [15:0] e_rd   = '0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [15:0] a, input logic [9:0] s,
                                               input logic [2:0] b);
        if (a < WORDS)         return model_mem[a[11:0]];
        else if (a == 16'h1040) return {6'h0, s};
        else if (a == 16'h1050) return {13'h0, b};
        else                    return 16'h0000;
    endfunction

    function automatic string read_tag(input logic [15:0] a);
        if (a < WORDS)          return "R1";
        else if (a == 16'h1040) return "R5";
        else if (a == 16'h1050) return "R6";
        else                    return "R7";
    endfunction

    // One bus access: inputs change after the rising edge, results are
    // checked just after the following falling edge.
    task automatic op(input logic [15:0] a, input logic [15:0] d, input logic r, input logic w,
                      input logic [9:0] s, input logic [2:0] b, input string tag);
        @(posedge clk);
        #0.2;
        // R10: nothing moved at the rising edge
        chk("R10 rdata", rdata, e_rd);
        chk("R10 ledr", {6'h0, ledr}, {6'h0, e_ledr});
        chk("R10 ledg", {8'h0, ledg}, {8'h0, e_ledg});
        #0.8;
        addr = a; wdata = d; rd_en = r; wr_en = w; sw_in = s; btn_in = b;
        e_rd = r ? model_read(a, s, b) : 16'h0000;
        if (w) begin
            if (a < WORDS)          model_mem[a[11:0]] = d;
            else if (a == 16'h1000) e_ledr = d[9:0];
            else if (a == 16'h1010) e_ledg = d[7:0];
        end
        @(negedge clk);
        #1;
        chk(r ? tag : "R2 idle", rdata, e_rd);
        chk({tag, " ledr R3"}, {6'h0, ledr}, {6'h0, e_ledr});
        chk({tag, " ledg R4"}, {8'h0, ledg}, {8'h0, e_ledg});
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        #1;
        e_ledr = '0; e_ledg = '0; e_rd = '0;
        chk("R9 rdata", rdata, 16'h0);
        chk("R9 ledr", {6'h0, ledr}, 16'h0);
        chk("R9 ledg", {8'h0, ledg}, 16'h0);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        logic [15:0] ra;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        do_reset();

        // R1: fill every RAM word with a distinct pattern
        for (int i = 0; i < WORDS; i++)
            op(16'(i), 16'(i * 7 + 16'h1234), 1'b0, 1'b1, '0, '0, "R1 fill");
        op(16'h0000, 16'h0, 1'b1, 1'b0, '0, '0, "R1 first word");
        op(16'h0FFF, 16'h0, 1'b1, 1'b0, '0, '0, "R1 last word");

        // R3 / R4: narrow LED fields keep only their low bits
        op(16'h1000, 16'hFFFF, 1'b0, 1'b1, '0, '0, "R3 ledr write");
        op(16'h1010, 16'hABCD, 1'b0, 1'b1, '0, '0, "R4 ledg write");
        // R5 / R6 input ports
        op(16'h1040, 16'h0, 1'b1, 1'b0, 10'h2A5, 3'b000, "R5 switches");
        op(16'h1050, 16'h0, 1'b1, 1'b0, 10'h3FF, 3'b101, "R6 buttons");
        op(16'h1050, 16'h0, 1'b1, 1'b0, 10'h000, 3'b111, "R6 buttons all");
        // R7 write-only and unmapped reads
        op(16'h1000, 16'h0, 1'b1, 1'b0, 10'h3FF, 3'b111, "R7 ledr read");
        op(16'h1010, 16'h0, 1'b1, 1'b0, 10'h3FF, 3'b111, "R7 ledg read");
        op(16'h2000, 16'h0, 1'b1, 1'b0, 10'h3FF, 3'b111, "R7 unmapped read");
        // R8 ignored writes, then look at LEDs and aliased RAM words
        op(16'h1040, 16'h5555, 1'b0, 1'b1, '0, '0, "R8 sw write");
        op(16'h1050, 16'h6666, 1'b0, 1'b1, '0, '0, "R8 btn write");
        op(16'h2000, 16'h7777, 1'b0, 1'b1, '0, '0, "R8 unmapped write");
        op(16'h0000, 16'h0, 1'b1, 1'b0, '0, '0, "R8 alias word 0");
        op(16'h0040, 16'h0, 1'b1, 1'b0, '0, '0, "R8 alias word 0x40");
        op(16'h0050, 16'h0, 1'b1, 1'b0, '0, '0, "R8 alias word 0x50");
        // R11 read and write one word on the same edge
        op(16'h0123, 16'hBEEF, 1'b1, 1'b1, '0, '0, "R11 same-edge old data");
        op(16'h0123, 16'h0, 1'b1, 1'b0, '0, '0, "R11 new data stored");
        // R9 reset clears LEDs but keeps RAM
        do_reset();
        op(16'h0123, 16'h0, 1'b1, 1'b0, '0, '0, "R9 RAM kept");

        // Random traffic mixed over all regions
        for (int k = 0; k < 3000; k++) begin
            case ($urandom % 6)
                0, 1: ra = 16'($urandom % WORDS);
                2:    ra = 16'h1000;
                3:    ra = 16'h1010;
                4:    ra = ($urandom % 2) ? 16'h1040 : 16'h1050;
                default: begin
                    ra = 16'($urandom);
                    if (ra < 16'h1000 || ra == 16'h1000 || ra == 16'h1010 ||
                        ra == 16'h1040 || ra == 16'h1050) ra = 16'hF00F;
                end
            endcase
            op(ra, 16'($urandom), 1'($urandom), 1'($urandom), 10'($urandom), 3'($urandom),
               read_tag(ra));
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_miss++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end
endmodule